// File: doc/BRIEF.md
# FSK Carrier Detect Output Gater

This block sits behind an FSK demodulator and an in-band energy detector in a caller-number receiver. It decides when the demodulated serial stream may reach the host. It drives an active-low carrier-detect flag. It also drives two gated data outputs: a main stream and a short stream. All timing is measured in ticks of a fixed-rate strobe. With the default parameters the strobe period is 0.5 ms.

Carrier-detect asserts once in-band energy has been present without a break for a qualification time, 15 ms by default. From then on the main output carries every demodulated bit, including the alternating seizure preamble. The short output stays at idle mark until a further unbroken run of mark bits has been seen, 12.5 ms by default, so that the preamble is stripped from it. Carrier-detect is released only after energy has been absent for a hold-off time, 30 ms by default. Shorter gaps in energy leave carrier-detect and the short-output release as they are.

Top module: `cdg_gater`

## Requirements
- R1: Out of reset, cd_n_o is 1, data_o is 0 and short_o is 1.
- R2: cd_n_o goes to 0 at the tick that completes QUAL_TICKS ticks with energy_ok high throughout. A single clock with energy_ok low restarts that count.
- R3: While cd_n_o is 1, data_o is 0, whatever rx_bit does.
- R4: While cd_n_o is 0, data_o equals rx_bit delayed by one clock. This includes alternating 1/0 preamble bits.
- R5: After carrier-detect asserts, short_o stays 1 until MARK_TICKS ticks have been counted with energy present and no space strobe. The short output is then released.
- R6: A bit_valid pulse with rx_bit equal to 0 (a space) before release restarts the mark count from zero.
- R7: Once released, short_o equals rx_bit delayed by one clock. When cd_n_o returns to 1, short_o returns to 1.
- R8: cd_n_o returns to 1 at the tick that completes HOLD_TICKS ticks with energy_ok low throughout. Any clock with energy_ok high clears that count.
- R9: An energy gap shorter than the hold-off keeps cd_n_o at 0 and keeps the short output released.
- R10: After a release, carrier-detect needs a fresh qualification, and the short output must be qualified again by a new mark run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock timing strobe (0.5 ms by default) |
| energy_ok | input | 1 | In-band energy present |
| rx_bit | input | 1 | Demodulated bit, 1 = mark, 0 = space |
| bit_valid | input | 1 | One-clock strobe marking a decided bit on rx_bit |
| cd_n_o | output | 1 | Carrier detect, active low |
| data_o | output | 1 | Main gated data, 0 when no carrier |
| short_o | output | 1 | Preamble-stripped data, 1 until released |

## Verification
The bench first breaks the energy flag for one clock just before qualification. A design that kept counting would assert carrier-detect a tick early. It then sends a space strobe partway through the mark window. A design that ignored it would release the short output too soon and show a 0 where idle mark is expected. An energy gap of one tick less than the hold-off is followed by a second such gap. This catches a hold counter that is not cleared when energy returns, or one that drops the carrier a tick late or early. A final requalification checks that the short output is re-armed and not left released from the previous call.

// File: rtl/cdg_pkg.sv
package cdg_pkg;
  // Counter width large enough to hold 0 .. limit-1
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

  typedef enum logic {
    CARRIER_OFF = 1'b0,
    CARRIER_ON  = 1'b1
  } carrier_e;
endpackage

// File: rtl/cdg_tick_count.sv
module cdg_tick_count #(
  parameter int unsigned LIMIT = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic hit
);
  localparam int unsigned W = cdg_pkg::cnt_width(LIMIT);

  logic [W-1:0] cnt_q;

  assign hit = adv && !clr && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr || hit) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cdg_qualifier.sv
module cdg_qualifier #(
  parameter int unsigned QUAL_TICKS = 30,
  parameter int unsigned HOLD_TICKS = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic energy_ok,
  output logic carrier,
  output logic cd_n
);
  import cdg_pkg::*;

  carrier_e state_q;
  logic     on_now;
  logic     qual_hit;
  logic     hold_hit;

  assign on_now = (state_q == CARRIER_ON);

  // Counts ticks of unbroken energy while no carrier is declared
  cdg_tick_count #(.LIMIT(QUAL_TICKS)) u_qual (
    .clk (clk),
    .rst (rst),
    .clr (on_now || !energy_ok),
    .adv (tick && energy_ok && !on_now),
    .hit (qual_hit)
  );

  // Counts ticks of unbroken silence while carrier is declared
  cdg_tick_count #(.LIMIT(HOLD_TICKS)) u_hold (
    .clk (clk),
    .rst (rst),
    .clr (!on_now || energy_ok),
    .adv (tick && !energy_ok && on_now),
    .hit (hold_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CARRIER_OFF;
      cd_n    <= 1'b1;
    end else if (qual_hit) begin
      state_q <= CARRIER_ON;
      cd_n    <= 1'b0;
    end else if (hold_hit) begin
      state_q <= CARRIER_OFF;
      cd_n    <= 1'b1;
    end
  end

  assign carrier = on_now;
endmodule

// File: rtl/cdg_mark_window.sv
module cdg_mark_window #(
  parameter int unsigned MARK_TICKS = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic energy_ok,
  input  logic carrier,
  input  logic rx_bit,
  input  logic bit_valid,
  output logic open
);
  logic space_seen;
  logic mark_hit;

  assign space_seen = bit_valid && !rx_bit;

  cdg_tick_count #(.LIMIT(MARK_TICKS)) u_mark (
    .clk (clk),
    .rst (rst),
    .clr (!carrier || open || space_seen),
    .adv (tick && energy_ok && carrier && !open),
    .hit (mark_hit)
  );

  always_ff @(posedge clk) begin
    if (rst || !carrier) begin
      open <= 1'b0;
    end else if (mark_hit) begin
      open <= 1'b1;
    end
  end
endmodule

// File: rtl/cdg_out_stage.sv
module cdg_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic carrier,
  input  logic open,
  input  logic rx_bit,
  output logic data_q,
  output logic short_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= 1'b0;
      short_q <= 1'b1;
    end else begin
      data_q  <= carrier && rx_bit;
      short_q <= (carrier && open) ? rx_bit : 1'b1;
    end
  end
endmodule

// File: rtl/cdg_gater.sv
module cdg_gater #(
  parameter int unsigned QUAL_TICKS = 30,
  parameter int unsigned MARK_TICKS = 25,
  parameter int unsigned HOLD_TICKS = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic energy_ok,
  input  logic rx_bit,
  input  logic bit_valid,
  output logic cd_n_o,
  output logic data_o,
  output logic short_o
);
  logic carrier;
  logic open;

  cdg_qualifier #(
    .QUAL_TICKS (QUAL_TICKS),
    .HOLD_TICKS (HOLD_TICKS)
  ) u_qual (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .energy_ok (energy_ok),
    .carrier   (carrier),
    .cd_n      (cd_n_o)
  );

  cdg_mark_window #(.MARK_TICKS(MARK_TICKS)) u_mark (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .energy_ok (energy_ok),
    .carrier   (carrier),
    .rx_bit    (rx_bit),
    .bit_valid (bit_valid),
    .open      (open)
  );

  cdg_out_stage u_out (
    .clk     (clk),
    .rst     (rst),
    .carrier (carrier),
    .open    (open),
    .rx_bit  (rx_bit),
    .data_q  (data_o),
    .short_q (short_o)
  );
endmodule

// File: rtl/cdg_gater_checker.sv
module cdg_gater_checker (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic energy_ok,
  input logic rx_bit,
  input logic cd_n_o,
  input logic data_o,
  input logic short_o
);
  // R2: carrier can only be declared on a tick with energy present
  a_r2_assert_on_energy_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(cd_n_o) |-> ($past(energy_ok) && $past(tick)));

  // R3: no data leaks while carrier is not declared
  a_r3_data_low_no_carrier: assert property (@(posedge clk) disable iff (rst)
    $past(cd_n_o) |-> !data_o);

  // R4: main output follows the demodulated bit under carrier
  a_r4_data_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(cd_n_o) |-> (data_o == $past(rx_bit)));

  // R7: short output idles at mark without carrier
  a_r7_short_idle_no_carrier: assert property (@(posedge clk) disable iff (rst)
    $past(cd_n_o) |-> short_o);

  // R8: carrier is released only on a tick with energy absent
  a_r8_release_on_silent_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(cd_n_o) |-> (!$past(energy_ok) && $past(tick)));
endmodule

bind cdg_gater cdg_gater_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .energy_ok (energy_ok),
  .rx_bit    (rx_bit),
  .cd_n_o    (cd_n_o),
  .data_o    (data_o),
  .short_o   (short_o)
);

// File: tb/cdg_gater_tb_top.sv
module cdg_gater_tb_top;
  localparam int unsigned QT = 4;
  localparam int unsigned MT = 3;
  localparam int unsigned HT = 5;

  logic clk = 1'b0;
  logic rst;
  logic tick;
  logic energy_ok;
  logic rx_bit;
  logic bit_valid;
  logic cd_n_o;
  logic data_o;
  logic short_o;

  always #10 clk = ~clk;

  cdg_gater #(.QUAL_TICKS(QT), .MARK_TICKS(MT), .HOLD_TICKS(HT)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .energy_ok (energy_ok),
    .rx_bit    (rx_bit),
    .bit_valid (bit_valid),
    .cd_n_o    (cd_n_o),
    .data_o    (data_o),
    .short_o   (short_o)
  );

  typedef struct {
    logic  cd_n;
    logic  data;
    logic  shrt;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  event sample_ev;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  // Driver side: queue the expectation and wake the monitor
  task automatic expect_now(input logic cd, input logic d, input logic s, input string tag);
    exp_t e;
    e.cd_n = cd;
    e.data = d;
    e.shrt = s;
    e.tag  = tag;
    exp_q.push_back(e);
    -> sample_ev;
  endtask

  // Monitor side: compare outputs against each queued item
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (cd_n_o !== e.cd_n || data_o !== e.data || short_o !== e.shrt) begin
          errors++;
          $display("FAIL %s: actual cd_n=%b data=%b short=%b expected cd_n=%b data=%b short=%b",
                   e.tag, cd_n_o, data_o, short_o, e.cd_n, e.data, e.shrt);
        end
      end
    end
  end

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (9) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick = 1'b0; energy_ok = 1'b0; rx_bit = 1'b1; bit_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    expect_now(1'b1, 1'b0, 1'b1, "R1 reset state");

    // R2 / R3: not yet qualified, data stays low
    energy_ok = 1'b1;
    run_ticks(3); settle();
    expect_now(1'b1, 1'b0, 1'b1, "R2 R3 three ticks no carrier");
    energy_ok = 1'b0;
    @(negedge clk);
    energy_ok = 1'b1;
    run_ticks(3); settle();
    expect_now(1'b1, 1'b0, 1'b1, "R2 dip restarts qualification");
    run_ticks(1); settle();
    expect_now(1'b0, 1'b1, 1'b1, "R2 carrier on fourth tick");

    // R4: preamble passes on main output, short held
    rx_bit = 1'b0; settle();
    expect_now(1'b0, 1'b0, 1'b1, "R4 R5 space on main, short idle");
    rx_bit = 1'b1; settle();
    expect_now(1'b0, 1'b1, 1'b1, "R4 mark on main");

    // R6: space strobe restarts the mark window
    run_ticks(2);
    rx_bit = 1'b0; bit_valid = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0; rx_bit = 1'b1;
    run_ticks(2);
    rx_bit = 1'b0; settle();
    expect_now(1'b0, 1'b0, 1'b1, "R6 space restarted window");
    rx_bit = 1'b1;
    run_ticks(1);
    rx_bit = 1'b0; settle();
    expect_now(1'b0, 1'b0, 1'b0, "R5 R7 short released follows space");
    rx_bit = 1'b1; settle();
    expect_now(1'b0, 1'b1, 1'b1, "R7 short follows mark");

    // R9: gap shorter than hold-off
    rx_bit = 1'b0; energy_ok = 1'b0;
    run_ticks(4); settle();
    expect_now(1'b0, 1'b0, 1'b0, "R9 short gap keeps carrier and release");
    energy_ok = 1'b1;
    @(negedge clk);
    energy_ok = 1'b0;
    run_ticks(4); settle();
    expect_now(1'b0, 1'b0, 1'b0, "R8 energy return cleared hold count");
    run_ticks(1); settle();
    expect_now(1'b1, 1'b0, 1'b1, "R8 R7 release on fifth silent tick");
    rx_bit = 1'b1; settle();
    expect_now(1'b1, 1'b0, 1'b1, "R3 data low after release");

    // R10: requalification and re-armed short window
    energy_ok = 1'b1;
    run_ticks(3); settle();
    expect_now(1'b1, 1'b0, 1'b1, "R10 needs full qualification again");
    run_ticks(1);
    rx_bit = 1'b0; settle();
    expect_now(1'b0, 1'b0, 1'b1, "R10 short re-armed");
    rx_bit = 1'b1;
    run_ticks(2);
    rx_bit = 1'b0; settle();
    expect_now(1'b0, 1'b0, 1'b1, "R5 still held one tick early");
    rx_bit = 1'b1;
    run_ticks(1);
    rx_bit = 1'b0; settle();
    expect_now(1'b0, 1'b0, 1'b0, "R10 short released again");

    settle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule